// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block watches a bank of general-purpose pins and raises an interrupt request whenever a pin that is set up as an input shows a level other than the one held in the input snapshot register. The snapshot is the value software last read from the port. Each read strobe loads the current pin levels into the snapshot, and the snapshot is brought out so that the read data path can return it. The request is a live comparison, not a latched event. It goes away when the pin returns to its old level, and it goes away when a read refreshes the snapshot.

The output is a pull-down enable for an open-drain, active-low interrupt pad: 1 means the line is pulled low. A small counter filters both edges. A mismatch must persist for a set number of clock cycles before the request appears, and a clean state must persist for a set number of cycles before it is withdrawn. These two counts stand in for the settling time of a few microseconds that the interrupt line allows. The pin levels are expected to be synchronized already. The snapshot holds raw pin levels, taken before any polarity inversion that a read path may apply, so changing the polarity setting never causes an interrupt.

Top module: `input_change_irq`

## Requirements
- R1: While reset is active and just after it, `irqPullDown` is 0 and `capturedLevels` is all ones.
- R2: A pin whose `dirIsInput` bit is 1 and whose `pinLevel` differs from its `capturedLevels` bit causes `irqPullDown` to become 1 on the RISE_CYCLES-th consecutive clock edge at which the mismatch is present.
- R3: A pin whose `dirIsInput` bit is 0 never causes `irqPullDown` to assert, whatever its level.
- R4: When every input pin again matches the snapshot, `irqPullDown` returns to 0 on the FALL_CYCLES-th consecutive clock edge without a mismatch.
- R5: A clock edge with `readStrobe` at 1 loads `pinLevel` into `capturedLevels`. This removes the mismatch, and the request clears FALL_CYCLES edges later under the rule of R4.
- R6: Turning a pin from output (`dirIsInput` 0) to input (`dirIsInput` 1) while its level differs from the snapshot raises the request after RISE_CYCLES edges, just as a pin change would.
- R7: A mismatch that lasts fewer than RISE_CYCLES edges does not raise the request. A match that lasts fewer than FALL_CYCLES edges does not drop an active request.
- R8: When a pin changes in the same cycle as a read strobe, the snapshot takes the new level and no interrupt follows.
- R9: Without `readStrobe`, `capturedLevels` keeps its value through pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pinLevel | input | WIDTH | Synchronized pin levels |
| dirIsInput | input | WIDTH | Per-pin direction, 1 = input, 0 = output |
| readStrobe | input | 1 | One-cycle pulse marking a read of the input port |
| capturedLevels | output | WIDTH | Input snapshot register (raw levels) |
| irqPullDown | output | 1 | Pull-down enable for the active-low interrupt pad |

## Verification
The clash of interest is a read strobe at the same edge at which a pin takes a new level. Refreshing the snapshot and detecting a change then meet in one cycle, and the snapshot must take the new level without any request following. The bench drives the new pin value and the strobe at the same falling edge. It then checks that the snapshot shows the new value one edge later and that `irqPullDown` stays at 0 for longer than the assert window. A second overlap, a read that arrives while a request is active, is judged by checking that the request clears exactly FALL_CYCLES edges after the capture.

// File: rtl/ici_pkg.sv
package ici_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic cntInc;
    logic cntClr;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic mismatch;
    logic hitRise;
    logic hitFall;
  } dpStatus_t;

  typedef enum logic {
    S_QUIET  = 1'b0,
    S_RAISED = 1'b1
  } irqState_t;

endpackage

// File: rtl/ici_datapath.sv
module ici_datapath
  import ici_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int RISE_CYCLES = 4,
  parameter int FALL_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pinLevel,
  input  logic [WIDTH-1:0] dirIsInput,
  input  ctlStrobe_t       strobe,
  output dpStatus_t        status,
  output logic [WIDTH-1:0] snapshot
);

  localparam int MAX_DLY = (RISE_CYCLES > FALL_CYCLES) ? RISE_CYCLES : FALL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(RISE_CYCLES - 1);
  localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(FALL_CYCLES - 1);

  logic [WIDTH-1:0] bitArmed;
  logic [CNT_W-1:0] dwellCnt;

  // snapshot of raw pin levels, refreshed on each port read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snapshot <= '1;
    end else if (strobe.capture) begin
      snapshot <= pinLevel;
    end
  end

  // per-pin compare, masked by direction
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cmp
    assign bitArmed[gi] = dirIsInput[gi] & (pinLevel[gi] ^ snapshot[gi]);
  end

  // dwell counter shared by assert and deassert filters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwellCnt <= '0;
    end else if (strobe.cntClr) begin
      dwellCnt <= '0;
    end else if (strobe.cntInc) begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  always_comb begin
    status.mismatch = |bitArmed;
    status.hitRise  = (dwellCnt == RISE_LAST);
    status.hitFall  = (dwellCnt == FALL_LAST);
  end

endmodule

// File: rtl/ici_control.sv
module ici_control
  import ici_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       readStrobe,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       irqActive
);

  irqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_QUIET;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext      = state;
    strobe.capture = readStrobe;
    strobe.cntInc  = 1'b0;
    strobe.cntClr  = 1'b0;
    unique case (state)
      S_QUIET: begin
        if (!status.mismatch) begin
          strobe.cntClr = 1'b1;
        end else if (status.hitRise) begin
          strobe.cntClr = 1'b1;
          stateNext     = S_RAISED;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      S_RAISED: begin
        if (status.mismatch) begin
          strobe.cntClr = 1'b1;
        end else if (status.hitFall) begin
          strobe.cntClr = 1'b1;
          stateNext     = S_QUIET;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: stateNext = S_QUIET;
    endcase
  end

  assign irqActive = (state == S_RAISED);

endmodule

// File: rtl/input_change_irq.sv
module input_change_irq
  import ici_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int RISE_CYCLES = 4,
  parameter int FALL_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pinLevel,
  input  logic [WIDTH-1:0] dirIsInput,
  input  logic             readStrobe,
  output logic [WIDTH-1:0] capturedLevels,
  output logic             irqPullDown
);

  ctlStrobe_t ctlStrobe;
  dpStatus_t  dpStatus;

  ici_datapath #(
    .WIDTH      (WIDTH),
    .RISE_CYCLES(RISE_CYCLES),
    .FALL_CYCLES(FALL_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pinLevel  (pinLevel),
    .dirIsInput(dirIsInput),
    .strobe    (ctlStrobe),
    .status    (dpStatus),
    .snapshot  (capturedLevels)
  );

  ici_control u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .readStrobe(readStrobe),
    .status    (dpStatus),
    .strobe    (ctlStrobe),
    .irqActive (irqPullDown)
  );

endmodule

// File: rtl/input_change_irq_chk.sv
module input_change_irq_chk #(
  parameter int WIDTH       = 8,
  parameter int RISE_CYCLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] pinLevel,
  input logic [WIDTH-1:0] dirIsInput,
  input logic             readStrobe,
  input logic [WIDTH-1:0] capturedLevels,
  input logic             irqPullDown
);

  logic        inputDiff;
  logic [15:0] runLen;

  assign inputDiff = |((pinLevel ^ capturedLevels) & dirIsInput);

  // length of the current mismatch run while the request is idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runLen <= '0;
    end else if (inputDiff && !irqPullDown) begin
      if (runLen != 16'hFFFF) runLen <= runLen + 1'b1;
    end else begin
      runLen <= '0;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_idle_in_reset_r1: assert (irqPullDown == 1'b0 && capturedLevels == '1);
    end
  end

  p_rise_after_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqPullDown) |-> runLen == 16'(RISE_CYCLES));

  p_rise_needs_input_diff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqPullDown) |-> $past(inputDiff));

  p_fall_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqPullDown) |-> !$past(inputDiff));

  p_capture_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    readStrobe |=> capturedLevels == $past(pinLevel));

  p_hold_without_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !readStrobe |=> $stable(capturedLevels));

endmodule

bind input_change_irq input_change_irq_chk #(
  .WIDTH      (WIDTH),
  .RISE_CYCLES(RISE_CYCLES)
) u_chk (.*);

// File: tb/tb_input_change_irq.sv
module tb_input_change_irq;

  localparam int W    = 8;
  localparam int RISE = 4;
  localparam int FALL = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pinLevel = '1;
  logic [W-1:0] dirIsInput = '1;
  logic         readStrobe = 1'b0;
  logic [W-1:0] capturedLevels;
  logic         irqPullDown;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string        tag;
    logic         irq;
    logic         chkSnap;
    logic [W-1:0] snap;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  input_change_irq #(
    .WIDTH      (W),
    .RISE_CYCLES(RISE),
    .FALL_CYCLES(FALL)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pinLevel      (pinLevel),
    .dirIsInput    (dirIsInput),
    .readStrobe    (readStrobe),
    .capturedLevels(capturedLevels),
    .irqPullDown   (irqPullDown)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expIrq(input string tag, input logic irq);
    expItem_t it;
    it.tag = tag; it.irq = irq; it.chkSnap = 1'b0; it.snap = '0;
    expQ.push_back(it);
  endtask

  task automatic expBoth(input string tag, input logic irq, input logic [W-1:0] snap);
    expItem_t it;
    it.tag = tag; it.irq = irq; it.chkSnap = 1'b1; it.snap = snap;
    expQ.push_back(it);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        total++;
        if (irqPullDown !== it.irq) begin
          bad++;
          $display("FAIL %s irqPullDown actual=%b expected=%b", it.tag, irqPullDown, it.irq);
        end
        if (it.chkSnap) begin
          total++;
          if (capturedLevels !== it.snap) begin
            bad++;
            $display("FAIL %s capturedLevels actual=%h expected=%h", it.tag, capturedLevels, it.snap);
          end
        end
      end
    end
  end

  task automatic runAll();
    cyc(2);
    expBoth("R1 in reset", 1'b0, 8'hFF);
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
    expBoth("R1 after reset", 1'b0, 8'hFF);

    // R2: single input pin changes
    pinLevel = 8'hFE;
    cyc(RISE - 1);
    expIrq("R2 before window ends", 1'b0);
    cyc(1);
    expIrq("R2 asserted", 1'b1);

    // R4 / R7: pin returns, request held for FALL-1 edges then drops
    pinLevel = 8'hFF;
    cyc(FALL - 1);
    expIrq("R7 short match keeps request", 1'b1);
    cyc(1);
    expIrq("R4 return clears", 1'b0);

    // R7: glitch shorter than the assert window
    pinLevel = 8'hFD;
    cyc(RISE - 2);
    pinLevel = 8'hFF;
    cyc(RISE + 1);
    expIrq("R7 short glitch ignored", 1'b0);

    // R3: outputs never interrupt
    dirIsInput = 8'h0F;
    pinLevel   = 8'h0F;
    cyc(RISE + 2);
    expBoth("R3 output pins masked", 1'b0, 8'hFF);

    // R6: output to input while mismatching
    dirIsInput = 8'hFF;
    cyc(RISE - 1);
    expIrq("R6 before window ends", 1'b0);
    cyc(1);
    expIrq("R6 direction change raises", 1'b1);

    // R5: read refreshes snapshot and clears request
    readStrobe = 1'b1;
    cyc(1);
    readStrobe = 1'b0;
    expBoth("R5 capture visible", 1'b1, 8'h0F);
    cyc(FALL - 1);
    expIrq("R5 still active in fall window", 1'b1);
    cyc(1);
    expIrq("R5 read clears", 1'b0);

    // R9: snapshot holds without read
    pinLevel = 8'h3C;
    cyc(1);
    expBoth("R9 snapshot holds", 1'b0, 8'h0F);
    pinLevel = 8'h0F;
    cyc(RISE + 1);
    expBoth("R9 back to match", 1'b0, 8'h0F);

    // R8: pin change coinciding with a read
    pinLevel   = 8'hAA;
    readStrobe = 1'b1;
    cyc(1);
    readStrobe = 1'b0;
    expBoth("R8 snapshot takes new level", 1'b0, 8'hAA);
    cyc(RISE + 2);
    expIrq("R8 no interrupt after coincident read", 1'b0);

    // R2 with R3: one input bit among masked output bits
    dirIsInput = 8'h80;
    pinLevel   = 8'h2A;
    cyc(RISE);
    expIrq("R2 masked mix asserts on input bit", 1'b1);
    cyc(2);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL all-requirements watchdog actual=hung expected=finished");
      end
    join_any
    disable fork;
    cyc(1);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule